// File: doc/BRIEF.md
# Center-Aligned Three-Channel PWM with Double-Update Duty Buffering

This block produces three PWM channels from one shared up/down time base. The counter climbs from zero to a programmable peak and then falls back to zero, so each channel's pulse is centred on the turning point at zero. Every channel has two duty registers. Software writes the shadow register whenever it likes. The comparator uses only the live register.

Shadow values move into the live registers at fixed points in the count. In double-update mode they move at both turning points, zero and the peak. In single-update mode they move only at zero. While the time base is switched off, the live registers copy the shadows on every cycle. Each channel drives a high/low output pair. A per-pair mode bit selects one of two behaviours: the low side is the inverse of the high side, or both sides follow the raw signal.

Top module: `center_pwm`

## Requirements
- R1: While `tb_en` is 1 and `period_i` is P > 0, `cnt_o` steps by one on each clock in the order 0, 1, …, P, P-1, …, 1, 0, 1, … (a cycle of 2P clocks). With P = 0 it stays at 0. One clock after `tb_en` is low, `cnt_o` is 0.
- R2: While `tb_en` is 0, each live duty register takes its shadow value on every clock. All raw PWM signals are inactive during that time.
- R3: With `dbl_upd` = 1 and the time base running, shadow values are copied to the live registers at the clock edge where `cnt_o` equals 0. They are also copied at the edge where `cnt_o` equals `period_i`.
- R4: With `dbl_upd` = 0 and the time base running, the copy happens only at the edge where `cnt_o` equals 0. At the peak, the live values are kept.
- R5: Channel k's raw signal is 1 exactly when the time base is enabled and `cnt_o` is below live duty k. A duty of 0 keeps it at 0. A duty above `period_i` keeps it at 1 while enabled.
- R6: In complementary mode (mode bit k = 0), `pwm_l[k]` is the inverse of `pwm_h[k]`, and `pwm_h[k]` carries the raw signal.
- R7: In independent mode (mode bit k = 1), `pwm_h[k]` and `pwm_l[k]` both carry the raw signal.
- R8: A pulse on `mode_we` loads `mode_wdata` into the three mode bits (bit k belongs to pair k). The new mode applies from the next clock.
- R9: A write with `duty_we[k]` = 1 loads `duty_wdata` into shadow k only. While the time base is running, the write does not change channel k's output until the next transfer point.
- R10: After reset, `cnt_o` is 0, every shadow and live duty is 0, and all pairs are complementary, so `pwm_h` = 000 and `pwm_l` = 111.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tb_en | input | 1 | Time base enable |
| period_i | input | 15 | Peak value of the up/down count |
| dbl_upd | input | 1 | 1: transfer at zero and peak; 0: at zero only |
| duty_we | input | 3 | Per-channel shadow write strobe |
| duty_wdata | input | 15 | Shadow write data |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 3 | Mode bits, bit k for pair k (0 complementary, 1 independent) |
| cnt_o | output | 15 | Time base count |
| pwm_h | output | 3 | High-side outputs, bit k for pair k |
| pwm_l | output | 3 | Low-side outputs, bit k for pair k |

## Verification
The counter and all live/mode registers change on a rising edge. The outputs are combinational from those registers, so every result shows one edge after the inputs that caused it. A shadow write reaches the pins only after a second edge, the next transfer edge.

The bench changes inputs on the falling edge and updates its reference model at the rising edge, using the values that were present at that edge. It compares on the following falling edge. Before any copy, the model evaluates the transfer condition against the count as it stood before that edge, so a write and a transfer on the same edge resolve as the hardware does: the old shadow is copied.

// File: rtl/center_pwm_pkg.sv
package center_pwm_pkg;

  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } tb_dir_e;

  typedef enum logic {
    PAIR_COMP  = 1'b0,
    PAIR_INDEP = 1'b1
  } pair_mode_e;

  localparam int CPWM_CNT_W_DEF = 15;
  localparam int CPWM_NCH_DEF   = 3;

endpackage

// File: rtl/center_pwm_timebase.sv
module center_pwm_timebase
  import center_pwm_pkg::*;
#(
  parameter int CNT_W = CPWM_CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_evt_o,
  output logic             peak_evt_o
);

  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic [CNT_W-1:0] cnt_q;
  tb_dir_e          dir_q;
  logic [CNT_W-1:0] cnt_n;
  tb_dir_e          dir_n;
  logic             at_top;
  logic             at_bottom;

  // direction for the next cycle, given the current position
  function automatic tb_dir_e f_next_dir(input logic [CNT_W-1:0] c,
                                         input logic [CNT_W-1:0] p,
                                         input tb_dir_e d);
    if (p == ZERO)                   return DIR_UP;
    else if (d == DIR_UP && c >= p)  return DIR_DOWN;
    else if (d == DIR_DOWN && c == ZERO) return DIR_UP;
    else                             return d;
  endfunction

  // next count value for a given direction to move in
  function automatic logic [CNT_W-1:0] f_next_cnt(input logic [CNT_W-1:0] c,
                                                  input logic [CNT_W-1:0] p,
                                                  input tb_dir_e nd);
    if (p == ZERO)           return ZERO;
    else if (nd == DIR_UP)   return c + ONE;
    else                     return c - ONE;
  endfunction

  assign at_top    = (cnt_q == period_i);
  assign at_bottom = (cnt_q == ZERO);

  always_comb begin
    dir_n = f_next_dir(cnt_q, period_i, dir_q);
    cnt_n = f_next_cnt(cnt_q, period_i, dir_n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= ZERO;
      dir_q <= DIR_UP;
    end else if (!en_i) begin
      cnt_q <= ZERO;
      dir_q <= DIR_UP;
    end else begin
      cnt_q <= cnt_n;
      dir_q <= dir_n;
    end
  end

  assign cnt_o      = cnt_q;
  assign zero_evt_o = en_i & at_bottom;
  assign peak_evt_o = en_i & at_top;

  // R1
  hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (cnt_o == ZERO));

  // R1
  peak_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && period_i != ZERO && dir_q == DIR_UP && cnt_q == period_i)
      |=> (cnt_q == $past(cnt_q) - ONE));

  // R1
  floor_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && period_i != ZERO && dir_q == DIR_DOWN && cnt_q == ZERO)
      |=> (cnt_q == ONE));

endmodule

// File: rtl/center_pwm_duty.sv
module center_pwm_duty
  import center_pwm_pkg::*;
#(
  parameter int CNT_W = CPWM_CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             dbl_i,
  input  logic             zero_evt_i,
  input  logic             peak_evt_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic             we_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic             raw_o
);

  logic [CNT_W-1:0] shadow_q;
  logic [CNT_W-1:0] live_q;
  logic             xfer_evt;
  logic             run_xfer;

  // a channel is active while the count sits below its duty
  function automatic logic f_active(input logic             en,
                                    input logic [CNT_W-1:0] c,
                                    input logic [CNT_W-1:0] d);
    return en && (c < d);
  endfunction

  assign run_xfer = zero_evt_i | (dbl_i & peak_evt_i);
  assign xfer_evt = (!en_i) | run_xfer;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    shadow_q <= '0;
    else if (we_i) shadow_q <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        live_q <= '0;
    else if (xfer_evt) live_q <= shadow_q;
  end

  assign raw_o = f_active(en_i, cnt_i, live_q);

  // R2
  idle_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (live_q == $past(shadow_q)));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> !raw_o);

  // R3
  peak_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && dbl_i && cnt_i == period_i) |=> (live_q == $past(shadow_q)));

  // R3
  zero_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && cnt_i == '0) |=> (live_q == $past(shadow_q)));

  // R4
  single_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !dbl_i && cnt_i != '0) |=> $stable(live_q));

  // R5
  duty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q == '0) |-> !raw_o);

  // R5
  duty_over_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && live_q > period_i && cnt_i <= period_i) |-> raw_o);

endmodule

// File: rtl/center_pwm_pair.sv
module center_pwm_pair
  import center_pwm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mode_we_i,
  input  logic mode_d_i,
  input  logic raw_i,
  output logic out_h_o,
  output logic out_l_o
);

  pair_mode_e mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mode_q <= PAIR_COMP;
    else if (mode_we_i) mode_q <= pair_mode_e'(mode_d_i);
  end

  assign out_h_o = raw_i;
  assign out_l_o = (mode_q == PAIR_COMP) ? ~raw_i : raw_i;

  // R6
  comp_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == PAIR_COMP) |-> (out_l_o != out_h_o));

  // R7
  indep_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == PAIR_INDEP) |-> (out_l_o == out_h_o));

  // R8
  mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_we_i |=> (mode_q == pair_mode_e'($past(mode_d_i))));

endmodule

// File: rtl/center_pwm.sv
module center_pwm
  import center_pwm_pkg::*;
#(
  parameter int CNT_W = CPWM_CNT_W_DEF,
  parameter int NCH   = CPWM_NCH_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tb_en,
  input  logic [CNT_W-1:0] period_i,
  input  logic             dbl_upd,
  input  logic [NCH-1:0]   duty_we,
  input  logic [CNT_W-1:0] duty_wdata,
  input  logic             mode_we,
  input  logic [NCH-1:0]   mode_wdata,
  output logic [CNT_W-1:0] cnt_o,
  output logic [NCH-1:0]   pwm_h,
  output logic [NCH-1:0]   pwm_l
);

  logic [CNT_W-1:0] cnt;
  logic             zero_evt;
  logic             peak_evt;
  logic [NCH-1:0]   raw;

  center_pwm_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (tb_en),
    .period_i   (period_i),
    .cnt_o      (cnt),
    .zero_evt_o (zero_evt),
    .peak_evt_o (peak_evt)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    center_pwm_duty #(.CNT_W(CNT_W)) u_duty (
      .clk        (clk),
      .rst_n      (rst_n),
      .en_i       (tb_en),
      .dbl_i      (dbl_upd),
      .zero_evt_i (zero_evt),
      .peak_evt_i (peak_evt),
      .cnt_i      (cnt),
      .period_i   (period_i),
      .we_i       (duty_we[k]),
      .wdata_i    (duty_wdata),
      .raw_o      (raw[k])
    );

    center_pwm_pair u_pair (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_we_i (mode_we),
      .mode_d_i  (mode_wdata[k]),
      .raw_i     (raw[k]),
      .out_h_o   (pwm_h[k]),
      .out_l_o   (pwm_l[k])
    );
  end

  assign cnt_o = cnt;

  // R1
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tb_en && $past(tb_en) && $stable(period_i) && $past(cnt_o) <= period_i)
      |-> (cnt_o <= period_i));

endmodule

// File: tb/center_pwm_tb.sv
`timescale 1ns/1ps
module center_pwm_tb;

  localparam int W = 15;
  localparam int N = 3;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         tb_en;
  logic [W-1:0] period_i;
  logic         dbl_upd;
  logic [N-1:0] duty_we;
  logic [W-1:0] duty_wdata;
  logic         mode_we;
  logic [N-1:0] mode_wdata;
  logic [W-1:0] cnt_o;
  logic [N-1:0] pwm_h;
  logic [N-1:0] pwm_l;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // reference state
  int       m_t;
  int       m_buf [N];
  int       m_act [N];
  bit [N-1:0] m_mode;

  always #2 clk = ~clk;

  center_pwm u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .tb_en      (tb_en),
    .period_i   (period_i),
    .dbl_upd    (dbl_upd),
    .duty_we    (duty_we),
    .duty_wdata (duty_wdata),
    .mode_we    (mode_we),
    .mode_wdata (mode_wdata),
    .cnt_o      (cnt_o),
    .pwm_h      (pwm_h),
    .pwm_l      (pwm_l)
  );

  // triangle position from elapsed enabled clocks (R1)
  function automatic int exp_cnt();
    int p;
    int pos;
    p = int'(period_i);
    if (p == 0) return 0;
    pos = m_t % (2 * p);
    return (pos <= p) ? pos : 2 * p - pos;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic compare();
    int  c;
    bit  raw;
    c = exp_cnt();
    chk("R1 count", 32'(cnt_o), 32'(c));
    for (int k = 0; k < N; k++) begin
      raw = tb_en && (c < m_act[k]);
      chk($sformatf("R2 R3 R4 R5 R9 high ch%0d", k), 32'(pwm_h[k]), 32'(raw));
      if (m_mode[k])
        chk($sformatf("R7 low ch%0d", k), 32'(pwm_l[k]), 32'(raw));
      else
        chk($sformatf("R6 low ch%0d", k), 32'(pwm_l[k]), 32'(!raw));
    end
  endtask

  task automatic step();
    int c;
    @(posedge clk);
    c = exp_cnt();
    for (int k = 0; k < N; k++)
      if (!tb_en || c == 0 || (dbl_upd && c == int'(period_i))) m_act[k] = m_buf[k];
    for (int k = 0; k < N; k++)
      if (duty_we[k]) m_buf[k] = int'(duty_wdata);
    if (mode_we) m_mode = mode_wdata;
    if (!tb_en) m_t = 0; else m_t++;
    @(negedge clk);
    compare();
  endtask

  task automatic run(input int n);
    repeat (n) step();
  endtask

  task automatic wr_duty(input int k, input int v);
    duty_we    = N'(1) << k;
    duty_wdata = W'(v);
    step();
    duty_we    = '0;
  endtask

  task automatic wr_mode(input bit [N-1:0] m);
    mode_we    = 1'b1;
    mode_wdata = m;
    step();
    mode_we    = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240517));
    rst_n = 1'b0; tb_en = 1'b0; period_i = W'(10); dbl_upd = 1'b1;
    duty_we = '0; duty_wdata = '0; mode_we = 1'b0; mode_wdata = '0;
    m_t = 0; m_mode = '0;
    for (int k = 0; k < N; k++) begin m_buf[k] = 0; m_act[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 reset count", 32'(cnt_o), 32'd0);
    chk("R10 reset high", 32'(pwm_h), 32'd0);
    chk("R10 reset low", 32'(pwm_l), 32'd7);

    // R2: shadows written while disabled, outputs stay quiet
    wr_duty(0, 0); wr_duty(1, 5); wr_duty(2, 11);
    run(3);
    // R1 R3 R5: run with double update, duty 0 / mid / above period
    tb_en = 1'b1;
    run(25);
    // R9 R3: writes mid-count take effect at the next turning point
    wr_duty(1, 8);
    run(5);
    wr_duty(0, 3);
    run(30);
    // R4: single update
    dbl_upd = 1'b0;
    wr_duty(1, 2);
    run(12);
    wr_duty(2, 7);
    run(30);
    // R7 R8: independent mode for pair 1
    wr_mode(3'b010);
    run(22);
    wr_mode(3'b101);
    run(22);
    wr_mode(3'b000);
    // R1: period zero corner
    tb_en = 1'b0;
    run(3);
    period_i = '0;
    tb_en = 1'b1;
    wr_duty(0, 1);
    run(6);
    tb_en = 1'b0;
    run(2);

    // constrained random segments
    for (int s = 0; s < 40; s++) begin
      int p;
      p = $urandom_range(40, 1);
      period_i = W'(p);
      dbl_upd  = 1'($urandom_range(1, 0));
      wr_mode(N'($urandom_range(7, 0)));
      for (int k = 0; k < N; k++) wr_duty(k, $urandom_range(p + 2, 0));
      tb_en = 1'b1;
      for (int i = 0; i < 150; i++) begin
        if ($urandom_range(3, 0) == 0)
          wr_duty($urandom_range(N - 1, 0), $urandom_range(p + 2, 0));
        else if ($urandom_range(15, 0) == 0)
          wr_mode(N'($urandom_range(7, 0)));
        else
          step();
      end
      tb_en = 1'b0;
      run(2);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule